// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow

This block is a registered 32-bit arithmetic unit. It takes two operands, `opa` and `opb`, and an operation code, and computes one of several clamped results. There are signed saturating add and subtract, and a signed add that wraps but still reports overflow. There are unsigned saturating add and subtract. Two further modes first double `opb` with signed saturation and then add the doubled value to `opa`, or subtract it, again with signed saturation.

Every clamp and every detected overflow sets one sticky flag, `ovf_flag`. Operations never clear the flag. Only the dedicated `clr_flag` input clears it, and a set in the same cycle takes priority over the clear. A result is captured one clock edge after `in_valid` is sampled high, and `res_valid` marks that cycle.

Top module: `sat_alu`

## Requirements
- R1: While `rst_n` is low, `res`, `res_valid` and `ovf_flag` are all zero.
- R2: When `in_valid` is high at a rising edge, `res` and `res_valid`=1 appear after that edge. When `in_valid` is low, `res_valid` is 0 after the edge and `res` keeps its previous value.
- R3: Op code 0 is a signed saturating add. Overflow is detected when `opa` and `opb` have equal sign bits and the sign of the raw sum differs from the sign of `opa`. On overflow the result is 0x80000000 if `opa` is negative and 0x7FFFFFFF otherwise, and the flag is set.
- R4: Op code 1 is a signed saturating subtract (`opa`-`opb`). Overflow is detected when the sign bits of `opa` and `opb` differ and the sign of the raw difference differs from the sign of `opa`. The clamp and the flag follow R3.
- R5: Op code 2 returns `opa`+`opb` modulo 2^32 with no clamp, but it sets the flag on signed overflow as in R3.
- R6: Op code 3 is an unsigned saturating add. When the raw sum is below `opa` the result is 0xFFFFFFFF and the flag is set.
- R7: Op code 4 is an unsigned saturating subtract. When the raw difference is above `opa` the result is 0 and the flag is set.
- R8: Op codes 5 (add) and 6 (subtract) first double `opb` as a signed value: 0x7FFFFFFF with a saturation if `opb` >= 0x40000000, 0x80000000 with a saturation if `opb` <= 0xC0000000 (signed, this value included), and `opb`<<1 otherwise. A signed saturating add or subtract with `opa` then follows as in R3/R4. The flag is set if either stage saturates.
- R9: `ovf_flag` is sticky. Once set it stays set until cleared, and only an accepted operation can set it.
- R10: `clr_flag` clears `ovf_flag` at the next edge. If a set occurs in the same cycle, the flag ends up set.
- R11: Op code 7 is reserved. It yields a zero result with `res_valid`=1 and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 3 | Operation code (0..7, see R3-R11) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| clr_flag | input | 1 | Clear sticky overflow flag |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after in_valid |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle the properties that hold regardless of operand values:
- the flag persists unless cleared, cannot rise without an accepted operation, and drops after a clear with no operation;
- `res_valid` tracks the previous `in_valid`, and `res` holds on idle cycles;
- unsigned results never cross `opa` in the wrong direction, and the wrapping add equals the modulo sum.

Only the bench's scenarios can show the exact clamp values and the boundaries of the doubling stage. These include 0x40000000, 0xC0000000 and 0xC0000001, a doubling-only saturation, and the same-cycle clear-versus-set priority.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_SADD = 3'd0,
    OP_SSUB = 3'd1,
    OP_WADD = 3'd2,
    OP_UADD = 3'd3,
    OP_USUB = 3'd4,
    OP_DADD = 3'd5,
    OP_DSUB = 3'd6,
    OP_NONE = 3'd7
  } sat_op_e;
endpackage

// File: rtl/sat_dbl.sv
// Signed doubling of one operand with saturation.
module sat_dbl #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         sat
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic hi_sat;
  logic lo_sat;

  always_comb begin
    // positive and at least a quarter of the range
    hi_sat = !din[W-1] && din[W-2];
    // negative and at or below minus a quarter of the range
    lo_sat = din[W-1] && (!din[W-2] || (din[W-3:0] == '0));
    sat    = hi_sat || lo_sat;
    if (hi_sat)      dout = MAXP;
    else if (lo_sat) dout = MINN;
    else             dout = {din[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_sgn.sv
// Signed add/subtract with optional clamp on overflow.
module sat_sgn #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         wrap,
  output logic [W-1:0] y,
  output logic         ovf
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         signs_eq;
  logic         res_flip;

  always_comb begin
    raw      = sub ? (a - b) : (a + b);
    signs_eq = (a[W-1] == b[W-1]);
    res_flip = (raw[W-1] != a[W-1]);
    ovf      = res_flip && (sub ? !signs_eq : signs_eq);
    if (ovf && !wrap) y = a[W-1] ? MINN : MAXP;
    else              y = raw;
  end
endmodule

// File: rtl/sat_uns.sv
// Unsigned add/subtract clamped to the range ends.
module sat_uns #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         ovf
);
  logic [W:0] sum_ext;
  logic [W:0] dif_ext;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b};
    dif_ext = {1'b0, a} - {1'b0, b};
    if (sub) begin
      ovf = dif_ext[W];
      y   = ovf ? '0 : dif_ext[W-1:0];
    end else begin
      ovf = sum_ext[W];
      y   = ovf ? '1 : sum_ext[W-1:0];
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           clr_flag,
  output logic [W-1:0]   res,
  output logic           res_valid,
  output logic           ovf_flag
);
  sat_op_e      op_e;
  logic [W-1:0] dbl_y;
  logic         dbl_sat;
  logic [W-1:0] sgn_b;
  logic         sgn_sub;
  logic         sgn_wrap;
  logic [W-1:0] sgn_y;
  logic         sgn_ovf;
  logic [W-1:0] uns_y;
  logic         uns_ovf;
  logic         is_dbl;

  logic [W-1:0] res_d;
  logic         vld_d;
  logic         flag_d;
  logic         set_evt;
  logic         hit;

  assign op_e = sat_op_e'(op);

  sat_dbl #(.W(W)) u_dbl (
    .din  (opb),
    .dout (dbl_y),
    .sat  (dbl_sat)
  );

  always_comb begin
    is_dbl   = (op_e == OP_DADD) || (op_e == OP_DSUB);
    sgn_b    = is_dbl ? dbl_y : opb;
    sgn_sub  = (op_e == OP_SSUB) || (op_e == OP_DSUB);
    sgn_wrap = (op_e == OP_WADD);
  end

  sat_sgn #(.W(W)) u_sgn (
    .a    (opa),
    .b    (sgn_b),
    .sub  (sgn_sub),
    .wrap (sgn_wrap),
    .y    (sgn_y),
    .ovf  (sgn_ovf)
  );

  sat_uns #(.W(W)) u_uns (
    .a   (opa),
    .b   (opb),
    .sub (op_e == OP_USUB),
    .y   (uns_y),
    .ovf (uns_ovf)
  );

  // next-state logic
  always_comb begin
    unique case (op_e)
      OP_SADD, OP_SSUB, OP_WADD: begin res_d = sgn_y; hit = sgn_ovf; end
      OP_DADD, OP_DSUB:          begin res_d = sgn_y; hit = sgn_ovf || dbl_sat; end
      OP_UADD, OP_USUB:          begin res_d = uns_y; hit = uns_ovf; end
      default:                   begin res_d = '0;    hit = 1'b0; end
    endcase
    set_evt = in_valid && hit;
    vld_d   = in_valid;
    // set has priority over clear
    flag_d  = (ovf_flag && !clr_flag) || set_evt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      res_valid <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (in_valid) res <= res_d;
      res_valid <= vld_d;
      ovf_flag  <= flag_d;
    end
  end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] op,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic           clr_flag,
  input logic [W-1:0]   res,
  input logic           res_valid,
  input logic           ovf_flag
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_clear_chk: assert (res == '0 && !res_valid && !ovf_flag);
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(in_valid)));

  // R2
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));

  // R5
  wrap_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_WADD) |=> (res == $past(opa) + $past(opb)));

  // R6
  uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_UADD) |=> (res >= $past(opa)));

  // R7
  usub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_USUB) |=> (res <= $past(opa)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flag) |=> ovf_flag);

  // R9
  flag_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !in_valid) |=> !ovf_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !in_valid) |=> !ovf_flag);

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NONE && !clr_flag) |=> (res == '0 && ovf_flag == $past(ovf_flag)));
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_sat_alu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .opa       (opa),
  .opb       (opb),
  .clr_flag  (clr_flag),
  .res       (res),
  .res_valid (res_valid),
  .ovf_flag  (ovf_flag)
);

// File: tb/test_sat_alu.sv
module test_sat_alu;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        clr_flag;
  logic [31:0] res;
  logic        res_valid;
  logic        ovf_flag;

  int n_run;
  int n_fail;
  logic [31:0] exp_res;
  logic        exp_flag;

  sat_alu i_sat_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .clr_flag(clr_flag),
    .res(res), .res_valid(res_valid), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic logic [32:0] sfit(longint r);
    if (r > 64'sd2147483647)       return {1'b1, 32'h7FFFFFFF};
    else if (r < -64'sd2147483648) return {1'b1, 32'h80000000};
    else                           return {1'b0, r[31:0]};
  endfunction

  function automatic logic [32:0] model(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint d;
    logic   ds;
    logic [32:0] f;
    ds = 1'b0;
    d  = 2 * sb;
    if (sb >= 64'sd1073741824)       begin d = 64'sd2147483647;  ds = 1'b1; end
    else if (sb <= -64'sd1073741824) begin d = -64'sd2147483648; ds = 1'b1; end
    case (o)
      3'd0: return sfit(sa + sb);
      3'd1: return sfit(sa - sb);
      3'd2: begin f = sfit(sa + sb); return {f[32], a + b}; end
      3'd3: return (ua + ub > 64'sd4294967295) ? {1'b1, 32'hFFFFFFFF} : {1'b0, a + b};
      3'd4: return (ua < ub) ? {1'b1, 32'h0} : {1'b0, a - b};
      3'd5: begin f = sfit(sa + d); return {f[32] | ds, f[31:0]}; end
      3'd6: begin f = sfit(sa - d); return {f[32] | ds, f[31:0]}; end
      default: return {1'b0, 32'h0};
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5, 3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic v, input logic [2:0] o, input logic [31:0] a,
                     input logic [31:0] b, input logic c, input string ftag);
    logic [32:0] m;
    logic        s;
    @(negedge clk);
    in_valid = v; op = o; opa = a; opb = b; clr_flag = c;
    s = 1'b0;
    if (v) begin
      m = model(o, a, b);
      exp_res = m[31:0];
      s = m[32];
    end
    exp_flag = (exp_flag & ~c) | s;
    @(posedge clk);
    #1;
    check(v ? tag_of(o) : "R2", "res", res, exp_res);
    check("R2", "res_valid", {31'b0, res_valid}, {31'b0, v});
    check(ftag, "ovf_flag", {31'b0, ovf_flag}, {31'b0, exp_flag});
    in_valid = 1'b0; clr_flag = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0; clr_flag = 1'b0;
    exp_res = '0; exp_flag = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "res", res, 32'h0);
    check("R1", "res_valid", {31'b0, res_valid}, 32'h0);
    check("R1", "ovf_flag", {31'b0, ovf_flag}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3 signed add corners
    run(1, 3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, "R3");
    run(1, 3'd0, 32'h80000000, 32'hFFFFFFFF, 1'b1, "R3");
    run(1, 3'd0, 32'h7FFFFFFF, 32'h80000000, 1'b1, "R3");
    // R10 clear alone
    run(0, 3'd0, 32'h0, 32'h0, 1'b1, "R10");
    // R4 signed subtract corners
    run(1, 3'd1, 32'h80000000, 32'h00000001, 1'b0, "R4");
    run(1, 3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, "R4");
    run(1, 3'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1, "R4");
    // R5 wrap add keeps raw sum but flags
    run(1, 3'd2, 32'h7FFFFFFF, 32'h00000001, 1'b1, "R5");
    run(0, 3'd0, 32'h0, 32'h0, 1'b1, "R10");
    // R6 / R7 unsigned
    run(1, 3'd3, 32'hFFFFFFFF, 32'h00000001, 1'b0, "R6");
    run(1, 3'd3, 32'hFFFFFFF0, 32'h0000000F, 1'b1, "R6");
    run(1, 3'd4, 32'h00000000, 32'h00000001, 1'b1, "R7");
    run(1, 3'd4, 32'h00000005, 32'h00000005, 1'b1, "R7");
    // R8 doubling boundaries
    run(1, 3'd5, 32'h00000000, 32'h40000000, 1'b1, "R8");
    run(1, 3'd5, 32'h00000000, 32'h3FFFFFFF, 1'b1, "R8");
    run(1, 3'd5, 32'h00000000, 32'hC0000000, 1'b1, "R8");
    run(1, 3'd5, 32'h00000000, 32'hC0000001, 1'b1, "R8");
    run(1, 3'd5, 32'h00000001, 32'h3FFFFFFF, 1'b1, "R8");
    run(1, 3'd5, 32'h00000002, 32'h3FFFFFFF, 1'b1, "R8");
    run(1, 3'd6, 32'h00000000, 32'h3FFFFFFF, 1'b1, "R8");
    run(1, 3'd6, 32'hC0000000, 32'h40000000, 1'b1, "R8");
    // R10 set wins over clear in the same cycle
    run(1, 3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R10");
    // R9 sticky across clean operations and idle cycles
    run(1, 3'd0, 32'h1, 32'h2, 1'b0, "R9");
    run(0, 3'd0, 32'h0, 32'h0, 1'b0, "R9");
    // R11 reserved code, flag kept
    run(1, 3'd7, 32'h12345678, 32'h9ABCDEF0, 1'b0, "R11");
    run(1, 3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R11");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  o;
      a = $urandom();
      b = $urandom();
      o = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) a = {a[31], {31{a[30]}}};
      if ($urandom_range(0, 3) == 0) b = {b[31:30], 30'($urandom_range(0, 1))};
      run(($urandom_range(0, 4) != 0), o, a, b, ($urandom_range(0, 7) == 0), "R9");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule